// File: doc/BRIEF.md
# Profiling Sample Filter Unit

This block sits at the end of a profiling sample pipeline and decides, for every completed sample, whether it is kept for the trace buffer or dropped. Software programs a 64-bit filter control register through a simple write port and can read it back. Three filters can be switched on independently: latency, operation type and event. A sample is kept only when every filter that is switched on passes it.

The latency filter compares the sample's total latency against a minimum-latency threshold. The type filter checks the sample's operation class against a set of per-class enables and passes when any enabled class matches. The event filter requires the sample's event vector to contain every event chosen in a selection mask. The threshold and the mask arrive as inputs from registers held elsewhere. Any filter that is switched on but has an empty selection behaves as if it were switched off. This is a build-time choice.

Each valid sample produces a registered decision one cycle later, together with a one-cycle decision-valid pulse.

Top module: `psamp_filter`

## Requirements
- R1: Only control bits 0 (event filter on), 1 (type filter on), 2 (latency filter on), 16 (branch class), 17 (load class) and 18 (store class) are stored. A write takes effect on the next clock. All other bits read as zero and ignore writes. Read data shows the stored value.
- R2: While reset is asserted, and in the first cycle after it, dec_valid and dec_keep are low.
- R3: dec_valid is high in exactly the cycle after a cycle with smp_valid high. dec_keep is low whenever dec_valid is low.
- R4: With all three filters off, every sample is kept.
- R5: With the latency filter on, a sample whose latency is strictly less than min_lat is dropped. A latency equal to or above min_lat passes.
- R6: With the type filter on, a sample passes if it matches any enabled class. The class encoding is 0 other, 1 load, 2 store, 3 branch. Branch covers ordinary branches and exception returns. With the type filter off, the class enables have no effect.
- R7: Any sample with smp_atomic set counts as a store. A sample counts as a load only when it has class load, or when it has both smp_atomic and smp_ret_data set.
- R8: With the event filter on, a sample passes only if (smp_events & evt_sel) == evt_sel.
- R9: The keep decision is the AND of the latency, type and event results.
- R10: A filter that is on with an empty selection passes every sample. An empty selection means no class bits for the type filter, a zero mask for the event filter, or a zero min_lat for the latency filter.
- R11: A sample presented in the same cycle as a register write is judged with the settings that held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 64 | Control register write value |
| reg_rd_data | output | 64 | Control register read value |
| min_lat | input | LAT_W | Minimum-latency threshold |
| evt_sel | input | EVT_W | Event selection mask |
| smp_valid | input | 1 | Sample descriptor valid |
| smp_class | input | 2 | Operation class (0 other, 1 load, 2 store, 3 branch) |
| smp_atomic | input | 1 | Sample is an atomic operation |
| smp_ret_data | input | 1 | Atomic operation returns data |
| smp_latency | input | LAT_W | Sample total latency |
| smp_events | input | EVT_W | Sample event bit vector |
| dec_valid | output | 1 | Decision valid pulse |
| dec_keep | output | 1 | Decision: 1 keep, 0 drop |

## Verification
A decision is due one clock after its sample is presented. A register write shows on the read port one clock after the write strobe, and it changes decisions only for samples presented after that write cycle. The bench drives inputs on the falling edge. On each rising edge its model captures the expected decision, using the settings it held before any write in that same cycle. The outputs are compared on the next falling edge, so every comparison falls inside the cycle in which the result is due. Read data is compared only after the first write, so the bench does not rely on the reset value of the register.

// File: rtl/psf_pkg.sv
package psf_pkg;
  localparam int CTRL_W = 64;
  // control bit positions (software-visible, order is behaviour)
  localparam int B_EVT_ON = 0;
  localparam int B_TYP_ON = 1;
  localparam int B_LAT_ON = 2;
  localparam int B_BRANCH = 16;
  localparam int B_LOAD   = 17;
  localparam int B_STORE  = 18;

  typedef enum logic [1:0] {
    CLS_OTHER  = 2'd0,
    CLS_LOAD   = 2'd1,
    CLS_STORE  = 2'd2,
    CLS_BRANCH = 2'd3
  } op_class_e;

  // mask of the bits the register really holds
  function automatic logic [CTRL_W-1:0] impl_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    m[B_EVT_ON] = 1'b1;
    m[B_TYP_ON] = 1'b1;
    m[B_LAT_ON] = 1'b1;
    m[B_BRANCH] = 1'b1;
    m[B_LOAD]   = 1'b1;
    m[B_STORE]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/psf_ctrl_reg.sv
module psf_ctrl_reg
  import psf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              evt_on,
  output logic              typ_on,
  output logic              lat_on,
  output logic              br_sel,
  output logic              ld_sel,
  output logic              st_sel
);
  localparam logic [CTRL_W-1:0] KEEP_BITS = impl_mask();

  logic [CTRL_W-1:0] ctrl_q;

  // reset value is not defined for software; zero keeps simulation deterministic
  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (wr_en)  ctrl_q <= wr_data & KEEP_BITS;
  end

  assign rd_data = ctrl_q;
  assign evt_on  = ctrl_q[B_EVT_ON];
  assign typ_on  = ctrl_q[B_TYP_ON];
  assign lat_on  = ctrl_q[B_LAT_ON];
  assign br_sel  = ctrl_q[B_BRANCH];
  assign ld_sel  = ctrl_q[B_LOAD];
  assign st_sel  = ctrl_q[B_STORE];

  a_r1_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & KEEP_BITS));

  a_r1_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/psf_type_match.sv
module psf_type_match
  import psf_pkg::*;
#(
  parameter bit EMPTY_AS_OFF = 1'b1
) (
  input  logic      typ_on,
  input  logic      br_sel,
  input  logic      ld_sel,
  input  logic      st_sel,
  input  op_class_e cls,
  input  logic      atomic,
  input  logic      ret_data,
  output logic      type_ok
);
  logic is_load, is_store, is_branch, hit, any_sel;

  assign is_store  = (cls == CLS_STORE) || atomic;
  assign is_load   = (cls == CLS_LOAD)  || (atomic && ret_data);
  assign is_branch = (cls == CLS_BRANCH);
  assign hit       = (st_sel && is_store) || (ld_sel && is_load) || (br_sel && is_branch);
  assign any_sel   = br_sel || ld_sel || st_sel;

  generate
    if (EMPTY_AS_OFF) begin : g_empty_off
      assign type_ok = !typ_on || !any_sel || hit;
    end else begin : g_empty_drop
      assign type_ok = !typ_on || hit;
    end
  endgenerate
endmodule

// File: rtl/psf_decide.sv
module psf_decide #(
  parameter int LAT_W        = 16,
  parameter int EVT_W        = 64,
  parameter bit EMPTY_AS_OFF = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic             type_ok,
  input  logic             evt_on,
  input  logic             lat_on,
  input  logic [LAT_W-1:0] min_lat,
  input  logic [EVT_W-1:0] evt_sel,
  input  logic [LAT_W-1:0] smp_latency,
  input  logic [EVT_W-1:0] smp_events,
  output logic             dec_valid,
  output logic             dec_keep
);
  function automatic logic long_enough(input logic [LAT_W-1:0] lat,
                                       input logic [LAT_W-1:0] thr);
    return !(lat < thr);
  endfunction

  function automatic logic has_all(input logic [EVT_W-1:0] ev,
                                   input logic [EVT_W-1:0] sel);
    return (ev & sel) == sel;
  endfunction

  logic lat_ok, evt_ok, keep_now;

  generate
    if (EMPTY_AS_OFF) begin : g_empty_off
      assign lat_ok = !lat_on || long_enough(smp_latency, min_lat);
      assign evt_ok = !evt_on || has_all(smp_events, evt_sel);
    end else begin : g_empty_drop
      assign lat_ok = !lat_on || ((min_lat != '0) && long_enough(smp_latency, min_lat));
      assign evt_ok = !evt_on || ((evt_sel != '0) && has_all(smp_events, evt_sel));
    end
  endgenerate

  assign keep_now = lat_ok && type_ok && evt_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_keep  <= 1'b0;
    end else begin
      dec_valid <= smp_valid;
      dec_keep  <= smp_valid && keep_now;
    end
  end

  a_r3_decision_follows: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> dec_valid);

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !dec_valid && !dec_keep);

  a_r5_short_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && lat_on && (smp_latency < min_lat) |=> !dec_keep);

  a_r8_missing_event: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && evt_on && ((smp_events & evt_sel) != evt_sel) |=> !dec_keep);

  a_r9_type_veto: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !type_ok |=> !dec_keep);

  a_r4_all_off_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !evt_on && !lat_on && type_ok |=> dec_keep);
endmodule

// File: rtl/psamp_filter.sv
module psamp_filter
  import psf_pkg::*;
#(
  parameter int LAT_W        = 16,
  parameter int EVT_W        = 64,
  parameter bit EMPTY_AS_OFF = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [63:0]      reg_wr_data,
  output logic [63:0]      reg_rd_data,
  input  logic [LAT_W-1:0] min_lat,
  input  logic [EVT_W-1:0] evt_sel,
  input  logic             smp_valid,
  input  logic [1:0]       smp_class,
  input  logic             smp_atomic,
  input  logic             smp_ret_data,
  input  logic [LAT_W-1:0] smp_latency,
  input  logic [EVT_W-1:0] smp_events,
  output logic             dec_valid,
  output logic             dec_keep
);
  logic evt_on, typ_on, lat_on, br_sel, ld_sel, st_sel;
  logic type_ok;

  psf_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .rd_data (reg_rd_data),
    .evt_on  (evt_on),
    .typ_on  (typ_on),
    .lat_on  (lat_on),
    .br_sel  (br_sel),
    .ld_sel  (ld_sel),
    .st_sel  (st_sel)
  );

  psf_type_match #(.EMPTY_AS_OFF(EMPTY_AS_OFF)) u_type (
    .typ_on   (typ_on),
    .br_sel   (br_sel),
    .ld_sel   (ld_sel),
    .st_sel   (st_sel),
    .cls      (op_class_e'(smp_class)),
    .atomic   (smp_atomic),
    .ret_data (smp_ret_data),
    .type_ok  (type_ok)
  );

  psf_decide #(.LAT_W(LAT_W), .EVT_W(EVT_W), .EMPTY_AS_OFF(EMPTY_AS_OFF)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .type_ok     (type_ok),
    .evt_on      (evt_on),
    .lat_on      (lat_on),
    .min_lat     (min_lat),
    .evt_sel     (evt_sel),
    .smp_latency (smp_latency),
    .smp_events  (smp_events),
    .dec_valid   (dec_valid),
    .dec_keep    (dec_keep)
  );

  a_r3_keep_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_keep);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[63:19] == '0 && reg_rd_data[15:3] == '0);
endmodule

// File: tb/psamp_filter_tb.sv
`timescale 1ns/1ps
module psamp_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [63:0] reg_wr_data = '0;
  logic [63:0] reg_rd_data;
  logic [15:0] min_lat = '0;
  logic [63:0] evt_sel = '0;
  logic        smp_valid = 1'b0;
  logic [1:0]  smp_class = '0;
  logic        smp_atomic = 1'b0;
  logic        smp_ret_data = 1'b0;
  logic [15:0] smp_latency = '0;
  logic [63:0] smp_events = '0;
  logic        dec_valid, dec_keep;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R2";
  bit    done = 1'b0;

  // model state
  logic [63:0] m_ctrl = '0;
  bit          m_known = 1'b0;
  bit          exp_v = 1'b0;
  bit          exp_k = 1'b0;
  bit          after_rst = 1'b0;

  always #10 clk = ~clk;

  psamp_filter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .min_lat(min_lat), .evt_sel(evt_sel),
    .smp_valid(smp_valid), .smp_class(smp_class), .smp_atomic(smp_atomic),
    .smp_ret_data(smp_ret_data), .smp_latency(smp_latency), .smp_events(smp_events),
    .dec_valid(dec_valid), .dec_keep(dec_keep)
  );

  // behavioural expectation written from the requirements
  function automatic bit ref_keep(logic [63:0] c, int thr, logic [63:0] m,
                                  int cls, bit at, bit rd, int lat, logic [63:0] ev);
    bit ok = 1'b1;
    bit matched = 1'b0;
    if (c[2] && lat < thr) ok = 1'b0;                       // R5, R10
    if (c[0])
      for (int i = 0; i < 64; i++)
        if (m[i] && !ev[i]) ok = 1'b0;                      // R8
    if (c[1] && (c[16] || c[17] || c[18])) begin            // R6, R10
      if (c[18] && (cls == 2 || at)) matched = 1'b1;        // R7
      if (c[17] && (cls == 1 || (at && rd))) matched = 1'b1;
      if (c[16] && cls == 3) matched = 1'b1;
      if (!matched) ok = 1'b0;
    end
    return ok;                                              // R9
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_v = 1'b0; exp_k = 1'b0;
    end else begin
      exp_v = smp_valid;
      exp_k = smp_valid && ref_keep(m_ctrl, int'(min_lat), evt_sel, int'(smp_class),
                                    smp_atomic, smp_ret_data, int'(smp_latency), smp_events);
      if (reg_wr_en) begin                                  // R11: old settings used above
        m_ctrl  = reg_wr_data & 64'h0000_0000_0007_0007;    // R1
        m_known = 1'b1;
      end
    end
  end

  task automatic cmp(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n || !after_rst) begin
        cmp("R2 dec_valid", {63'b0, dec_valid}, 64'd0);
        cmp("R2 dec_keep",  {63'b0, dec_keep},  64'd0);
        if (rst_n) after_rst = 1'b1;
      end else begin
        cmp({"R3 ", cur_req, " dec_valid"}, {63'b0, dec_valid}, {63'b0, exp_v});
        cmp({cur_req, " dec_keep"}, {63'b0, dec_keep}, {63'b0, exp_k});
        if (m_known) cmp("R1 reg_rd_data", reg_rd_data, m_ctrl);
      end
    end
  end

  task automatic step(bit w, logic [63:0] wd, bit v, int cls, bit at, bit rd,
                      int lat, logic [63:0] ev);
    @(negedge clk);
    reg_wr_en    = w;
    reg_wr_data  = wd;
    smp_valid    = v;
    smp_class    = cls[1:0];
    smp_atomic   = at;
    smp_ret_data = rd;
    smp_latency  = lat[15:0];
    smp_events   = ev;
  endtask

  task automatic wr(logic [63:0] d);
    step(1'b1, d, 1'b0, 0, 1'b0, 1'b0, 0, '0);
  endtask

  task automatic smp(int cls, bit at, bit rd, int lat, logic [63:0] ev);
    step(1'b0, '0, 1'b1, cls, at, rd, lat, ev);
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, 0, 1'b0, 1'b0, 0, '0);
  endtask

  localparam logic [63:0] FE = 64'h1, FT = 64'h2, FL = 64'h4;
  localparam logic [63:0] BR = 64'h1_0000, LD = 64'h2_0000, ST = 64'h4_0000;

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    // R1: reserved bits dropped, implemented bits kept
    cur_req = "R1";
    wr('1); idle();
    wr(64'hA5A5_5A5A_F0F0_0F0F); idle();
    wr(64'h0000_0000_0005_0002); idle();
    // R4: all filters off
    cur_req = "R4";
    wr(64'h0007_0000); min_lat = 16'd500; evt_sel = 64'hFF;
    for (int c = 0; c < 4; c++) smp(c, 1'b0, 1'b0, 3, 64'h0);
    idle();
    // R5: latency boundary
    cur_req = "R5";
    wr(FL); min_lat = 16'd100; evt_sel = '0;
    smp(0, 0, 0, 99, 0); smp(0, 0, 0, 100, 0); smp(0, 0, 0, 101, 0); smp(0, 0, 0, 0, 0);
    idle();
    // R6: class OR and class bits ignored when type filter off
    cur_req = "R6";
    wr(FT | LD);
    for (int c = 0; c < 4; c++) smp(c, 0, 0, 0, 0);
    wr(FT | BR | ST);
    for (int c = 0; c < 4; c++) smp(c, 0, 0, 0, 0);
    wr(LD);
    for (int c = 0; c < 4; c++) smp(c, 0, 0, 0, 0);
    idle();
    // R7: atomic classification
    cur_req = "R7";
    wr(FT | ST); smp(0, 1, 0, 0, 0); smp(3, 1, 1, 0, 0);
    wr(FT | LD); smp(0, 1, 0, 0, 0); smp(0, 1, 1, 0, 0); smp(2, 1, 1, 0, 0);
    wr(FT | BR); smp(0, 1, 1, 0, 0); smp(3, 0, 0, 0, 0);
    idle();
    // R8: event superset
    cur_req = "R8";
    wr(FE); evt_sel = 64'hA;
    smp(0, 0, 0, 0, 64'hE); smp(0, 0, 0, 0, 64'h2); smp(0, 0, 0, 0, 64'hA);
    evt_sel = 64'h8000_0000_0000_0001;
    smp(0, 0, 0, 0, 64'h8000_0000_0000_0001); smp(0, 0, 0, 0, 64'h1);
    idle();
    // R9: AND of all three
    cur_req = "R9";
    wr(FE | FT | FL | LD); evt_sel = 64'h3; min_lat = 16'd10;
    smp(1, 0, 0, 10, 64'h3); smp(1, 0, 0, 9, 64'h3);
    smp(2, 0, 0, 10, 64'h3); smp(1, 0, 0, 10, 64'h1);
    idle();
    // R10: empty selections act as off
    cur_req = "R10";
    wr(FT); for (int c = 0; c < 4; c++) smp(c, 0, 0, 0, 0);
    wr(FE); evt_sel = '0; smp(0, 0, 0, 0, 0);
    wr(FL); min_lat = '0; smp(0, 0, 0, 0, 0);
    idle();
    // R11: write in same cycle as sample uses old settings
    cur_req = "R11";
    wr(64'h0); min_lat = 16'd50;
    step(1'b1, FL, 1'b1, 0, 0, 0, 5, 0);   // old: off -> keep
    smp(0, 0, 0, 5, 0);                    // new: latency on -> drop
    step(1'b1, 64'h0, 1'b1, 0, 0, 0, 5, 0); // old: on -> drop
    smp(0, 0, 0, 5, 0);
    idle();
    // mixed stimulus on all requirements
    cur_req = "R9";
    for (int i = 0; i < 400; i++) begin
      min_lat = 16'($urandom_range(0, 40));
      evt_sel = {$urandom, $urandom} & {$urandom, $urandom} & 64'h0000_00FF_0000_00FF;
      step(($urandom % 4) == 0, {$urandom, $urandom}, $urandom % 2,
           int'($urandom % 4), $urandom % 2, $urandom % 2,
           int'($urandom_range(0, 50)), {$urandom, $urandom} | 64'h0000_00F0_0000_00F0);
    end
    idle(); idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule